// File: doc/BRIEF.md
# Host-to-DSP Mailbox with Sticky Direction Flags

This block joins a host CPU bus to a DSP core through one shared 16-bit exchange word and a 16-bit status register. Each side can deposit a value in the exchange word. Each deposit raises a sticky flag that belongs to its direction. Bit 0 of the status register means "the DSP has posted a value". Bit 1 means "the host has posted a value". A flag clears when the opposite party reads the status register, so each side learns about new data exactly once.

The host sees a small window addressed by byte offset. Offsets 0 and 2 both map to the exchange word. Offset 4 maps to the status register. Every other offset reads as zero. The DSP side uses separate read and write strobes for the exchange word and for the status register.

The block also drives a stall output. If the DSP polls the status register and finds no host message, the stall output rises. The core can then halt instead of spinning on the register. The stall output stays high until the host next writes the exchange word.

Top module: `mbox_status`

## Requirements
- R1: A DSP write of the exchange word (`dsp_xs_wr`) stores `dsp_wdata` and sets status bit 0 on the next clock edge.
- R2: A host write at offset 0 or offset 2 loads `host_wdata` into the exchange word and sets status bit 1. If the DSP writes the exchange word in the same cycle, the host value is the one stored.
- R3: A host read at offset 0 or offset 2 returns the exchange word on `host_rdata` in the same cycle and changes no state.
- R4: A host read at offset 4 returns the status register as it was before the access. Status bit 0 is clear after that clock edge.
- R5: `dsp_st_rdata` always shows the status register. A DSP status read (`dsp_st_rd`) clears bit 1 at that clock edge.
- R6: A DSP status read while bit 1 is clear raises `dsp_wait` on the next cycle. `dsp_wait` stays high until a host write at offset 0 or 2, and it is low in the cycle after that write.
- R7: A DSP status write (`dsp_st_wr`) replaces all 16 status bits with `dsp_wdata`.
- R8: In any single cycle the updates apply in this order: flag clears first, then a DSP status replace, then flag sets. A set of bit 0 or bit 1 in the same cycle as a clear or a replace therefore leaves that bit at 1. A host write in the same cycle as a DSP status read leaves bit 1 set and raises no stall.
- R9: While `rst_n` is low, the exchange word, the status register and `dsp_wait` are all zero.
- R10: A host read at any offset other than 0, 2 or 4 returns zero and changes no state. A host write at any offset other than 0 or 2 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 4 | Host byte offset within the window |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data (combinational) |
| dsp_xs_wr | input | 1 | DSP write of the exchange word |
| dsp_st_rd | input | 1 | DSP read of the status register |
| dsp_st_wr | input | 1 | DSP write of the status register |
| dsp_wdata | input | 16 | DSP write data |
| dsp_xs_rdata | output | 16 | Exchange word as seen by the DSP |
| dsp_st_rdata | output | 16 | Status register as seen by the DSP |
| dsp_wait | output | 1 | Stall hint: DSP polled with no host message pending |

## Verification
The bench targets same-cycle collisions of the following kinds:
- a host write against a DSP status read;
- a host status read against a DSP exchange write;
- a DSP status replace against either set.

A design that applies these updates in the wrong order loses a message flag or leaves a stale one. The bench checks that a host status read returns the value from before the clear. A design that clears the flag first would report an empty mailbox. It also checks that the stall is released by a host write and by nothing else. A wrong stall would either hang the DSP or be dropped while the DSP is still polling. Finally, it reads and writes unmapped offsets to catch decode aliasing.

// File: rtl/mbox_status.sv
module mbox_status #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4,
  parameter int OFS_XS_A = 0,
  parameter int OFS_XS_B = 2,
  parameter int OFS_ST = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              dsp_xs_wr,
  input  logic              dsp_st_rd,
  input  logic              dsp_st_wr,
  input  logic [DATA_W-1:0] dsp_wdata,
  output logic [DATA_W-1:0] dsp_xs_rdata,
  output logic [DATA_W-1:0] dsp_st_rdata,
  output logic              dsp_wait
);
  localparam int DSP_FLAG  = 0;
  localparam int HOST_FLAG = 1;

  logic [DATA_W-1:0] xs_q, st_q, st_d;
  logic hit_xs, hit_st, h_post, h_st_rd;

  assign hit_xs  = (host_addr == ADDR_W'(OFS_XS_A)) || (host_addr == ADDR_W'(OFS_XS_B));
  assign hit_st  = (host_addr == ADDR_W'(OFS_ST));
  assign h_post  = host_wr && hit_xs;
  assign h_st_rd = host_rd && hit_st;

  assign host_rdata   = !host_rd ? '0 : hit_xs ? xs_q : hit_st ? st_q : '0;
  assign dsp_xs_rdata = xs_q;
  assign dsp_st_rdata = st_q;

  always_comb begin
    st_d = st_q;
    if (dsp_st_rd) st_d[HOST_FLAG] = 1'b0;
    if (h_st_rd)   st_d[DSP_FLAG]  = 1'b0;
    if (dsp_st_wr) st_d = dsp_wdata;
    if (dsp_xs_wr) st_d[DSP_FLAG]  = 1'b1;
    if (h_post)    st_d[HOST_FLAG] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xs_q     <= '0;
      st_q     <= '0;
      dsp_wait <= 1'b0;
    end else begin
      st_q <= st_d;
      if (h_post)         xs_q <= host_wdata;
      else if (dsp_xs_wr) xs_q <= dsp_wdata;
      if (h_post)                          dsp_wait <= 1'b0;
      else if (dsp_st_rd && !st_q[HOST_FLAG]) dsp_wait <= 1'b1;
    end
  end

  p_dsp_post_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_xs_wr && !h_post |=> xs_q == $past(dsp_wdata) && st_q[DSP_FLAG]);
  p_host_post_r2: assert property (@(posedge clk) disable iff (!rst_n)
    h_post |=> xs_q == $past(host_wdata) && st_q[HOST_FLAG]);
  p_host_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    h_st_rd && !dsp_xs_wr && !dsp_st_wr |=> !st_q[DSP_FLAG]);
  p_dsp_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_st_rd && !h_post && !dsp_st_wr |=> !st_q[HOST_FLAG]);
  p_wait_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_st_rd && !st_q[HOST_FLAG] && !h_post |=> dsp_wait);
  p_wait_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    h_post |=> !dsp_wait);
  p_collide_r8: assert property (@(posedge clk) disable iff (!rst_n)
    h_post && dsp_st_rd |=> st_q[HOST_FLAG] && !dsp_wait);
  p_unmapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && !hit_xs && !hit_st |-> host_rdata == '0);
endmodule

// File: tb/mbox_status_tb_top.sv
module mbox_status_tb_top;
  logic clk = 0, rst_n = 0;
  logic host_rd = 0, host_wr = 0, dsp_xs_wr = 0, dsp_st_rd = 0, dsp_st_wr = 0;
  logic [3:0] host_addr = 0;
  logic [15:0] host_wdata = 0, dsp_wdata = 0;
  logic [15:0] host_rdata, dsp_xs_rdata, dsp_st_rdata;
  logic dsp_wait;
  int checks = 0, fails = 0;
  logic [15:0] m_xs = 0, m_st = 0;
  logic m_wait = 0;

  always #10 clk = ~clk;

  mbox_status dut_i (.clk, .rst_n, .host_rd, .host_wr, .host_addr, .host_wdata, .host_rdata,
    .dsp_xs_wr, .dsp_st_rd, .dsp_st_wr, .dsp_wdata, .dsp_xs_rdata, .dsp_st_rdata, .dsp_wait);

  function automatic logic is_xs(logic [3:0] a); return a == 0 || a == 2; endfunction

  function automatic logic [15:0] exp_hr();
    if (!host_rd) return 16'h0;
    if (is_xs(host_addr)) return m_xs;
    if (host_addr == 4) return m_st;
    return 16'h0;
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, logic hr, logic hw, logic [3:0] a, logic [15:0] hd,
                      logic xw, logic sr, logic sw, logic [15:0] dd);
    logic post;
    logic [15:0] ns;
    @(negedge clk);
    host_rd = hr; host_wr = hw; host_addr = a; host_wdata = hd;
    dsp_xs_wr = xw; dsp_st_rd = sr; dsp_st_wr = sw; dsp_wdata = dd;
    #2;
    chk({tag, " host_rdata R3 R4 R10"}, host_rdata, exp_hr());
    chk({tag, " dsp_st_rdata R5"}, dsp_st_rdata, m_st);
    chk({tag, " dsp_xs_rdata R1 R2"}, dsp_xs_rdata, m_xs);
    chk({tag, " dsp_wait R6"}, {15'h0, dsp_wait}, {15'h0, m_wait});
    post = hw && is_xs(a);
    ns = m_st;
    if (sr) ns[1] = 0;
    if (hr && a == 4) ns[0] = 0;
    if (sw) ns = dd;
    if (xw) ns[0] = 1;
    if (post) ns[1] = 1;
    if (post) m_wait = 0; else if (sr && !m_st[1]) m_wait = 1;
    if (post) m_xs = hd; else if (xw) m_xs = dd;
    m_st = ns;
    @(posedge clk);
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (2) @(posedge clk);
    #2;
    chk("R9 reset xs", dsp_xs_rdata, 0);
    chk("R9 reset st", dsp_st_rdata, 0);
    chk("R9 reset wait", {15'h0, dsp_wait}, 0);
    @(negedge clk); rst_n = 1;
    step("R6 poll empty", 0,0,0,0, 0,1,0,0);
    step("R6 wait held", 0,0,0,0, 0,0,0,0);
    step("R2 host post off2", 0,1,2,16'hA5A5, 0,0,0,0);
    step("R3 host read off0", 1,0,0,0, 0,0,0,0);
    step("R5 dsp ack", 0,0,0,0, 0,1,0,0);
    step("R1 dsp post", 0,0,0,0, 1,0,0,16'h1234);
    step("R4 host status read", 1,0,4,0, 0,0,0,0);
    step("R4 after clear", 1,0,4,0, 0,0,0,0);
    step("R10 unmapped write", 0,1,6,16'hFFFF, 0,0,0,0);
    step("R10 unmapped read", 1,0,8,0, 0,0,0,0);
    step("R7 replace", 0,0,0,0, 0,0,1,16'hC3C0);
    step("R7 read back", 1,0,4,0, 0,0,0,0);
    step("R8 host post vs poll", 0,1,0,16'h0F0F, 0,1,0,0);
    step("R8 ack vs dsp post", 1,0,4,0, 1,0,0,16'h7777);
    step("R8 replace vs sets", 0,1,0,16'h2222, 1,0,1,16'h0000);
    step("R2 collision host wins", 0,1,2,16'hBEEF, 1,0,0,16'hDEAD);
    step("R8 read back", 1,0,0,0, 0,0,0,0);
    for (int i = 0; i < 3000; i++) begin
      int op = $urandom % 3;
      logic [3:0] a = ($urandom % 4 == 0) ? 4'($urandom) : 4'(2 * ($urandom % 3));
      step("RND", op == 1, op == 2, a, 16'($urandom),
           $urandom % 4 == 0, $urandom % 3 == 0, $urandom % 8 == 0, 16'($urandom));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule